// File: doc/BRIEF.md
# Delta-Sigma Conversion Timing Sequencer

This block sets the timing of conversions in the digital back end of a delta-sigma converter. It runs on a tick clock at twice the modulator clock rate, so one tick is half a modulator period. Counting in ticks lets it place every data-ready edge on the exact half-period boundary the conversion schedule needs, including a first-conversion lead-in of 28.5 modulator periods. The tick clock runs twice as fast in turbo operation as in normal operation, because the modulator clock doubles there. The block itself counts the same way in both cases.

A start/sync pulse, already aligned to the command-latch instant, samples the operating mode (normal or turbo), the 3-bit rate index and the conversion mode (single-shot or continuous). It then starts the sequence. Each completed conversion produces a one-tick done strobe, which loads the result register, and drives the active-low data-ready line low. A read acknowledge or a new start raises data-ready again. A power-down request halts everything.

Top module: `conv_timing_seq`

## Requirements
- R1: After reset, drdy_n_o is 1, done_o is 0 and busy_o is 0.
- R2: In continuous mode with turbo_i=0, the first done_o comes 57 + 2·C ticks after the clock edge that samples start_i. C is the continuous period for the rate index: 51192, 22780, 11532, 5916, 3116, 1724, 1036 for indices 0 to 6.
- R3: In continuous mode with turbo_i=1, the first done_o comes 210 + 2·C ticks after the sampling edge.
- R4: In continuous mode, each later done_o comes 2·C ticks after the previous one, for both values of turbo_i.
- R5: In single-shot mode, done_o comes 2·S ticks after the sampling edge, and then busy_o falls and no further done_o occurs. S is the single-shot count. With turbo_i=0 it is C+21 for index 0 and C+25 for the other indices. With turbo_i=1 it is C+25 for index 0 and C+29 for the other indices.
- R6: done_o is a one-tick pulse, and drdy_n_o goes low in the same tick that done_o is high.
- R7: drdy_n_o stays low after a completion until rd_ack_i or an accepted start_i raises it. A read in the same tick as a completion leaves it low.
- R8: A start_i pulse during a conversion abandons it and restarts the timing from the lead-in, counted from the new pulse.
- R9: While pd_i is 1, the counter is frozen, busy_o is 0, drdy_n_o is 1, no done_o is produced and start_i is ignored.
- R10: turbo_i, rate_i and cont_i are sampled only when start_i is accepted. Changes to them during a conversion do not change its timing or its mode.
- R11: Rate index 7 uses the timing of index 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the modulator clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| turbo_i | input | 1 | 1 selects turbo lead-in and single-shot counts |
| rate_i | input | 3 | Data-rate index |
| cont_i | input | 1 | 1 continuous, 0 single-shot |
| start_i | input | 1 | Start/sync pulse at the command-latch instant |
| pd_i | input | 1 | Power-down request |
| rd_ack_i | input | 1 | Result has been read; raises data-ready |
| drdy_n_o | output | 1 | Active-low data ready |
| done_o | output | 1 | One-tick conversion-done strobe |
| busy_o | output | 1 | A conversion sequence is running |

## Verification
The assertions check on every cycle the rules that hold locally. The done strobe lasts one tick and coincides with data-ready low. Power-down silences all outputs and freezes the counter. An accepted start restarts the sequence with data-ready high. The sampled settings stay unchanged while a conversion runs, and the counter cannot expire outside a run. Only the bench scenarios can show the exact tick counts: first-edge placement with each lead-in, steady spacing, single-shot counts in both modes, the index-7 mapping, restart timing and the effect of mid-run setting changes.

// File: rtl/cts_pkg.sv
package cts_pkg;

  localparam int unsigned RATE_W = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cts_state_e;

  // Continuous-mode period in modulator clocks; index 7 reuses index 6.
  function automatic int unsigned cont_periods(input logic [RATE_W-1:0] idx);
    int unsigned p;
    case (idx)
      3'd0:    p = 51192;
      3'd1:    p = 22780;
      3'd2:    p = 11532;
      3'd3:    p = 5916;
      3'd4:    p = 3116;
      3'd5:    p = 1724;
      default: p = 1036;
    endcase
    return p;
  endfunction

  // Extra modulator clocks a single-shot conversion needs over continuous.
  function automatic int unsigned single_extra(input logic [RATE_W-1:0] idx,
                                               input logic turbo);
    int unsigned e;
    if (idx == 3'd0) e = turbo ? 25 : 21;
    else             e = turbo ? 29 : 25;
    return e;
  endfunction

endpackage

// File: rtl/cts_rate_lut.sv
module cts_rate_lut
  import cts_pkg::*;
#(
  parameter int unsigned CNT_W           = 18,
  parameter int unsigned LEAD_NORM_HALF  = 57,
  parameter int unsigned LEAD_TURBO_HALF = 210
) (
  input  logic [RATE_W-1:0] rate,
  input  logic              turbo,
  output logic [CNT_W-1:0]  conv_half,
  output logic [CNT_W-1:0]  single_half,
  output logic [CNT_W-1:0]  lead_half
);

  int unsigned base_p;
  int unsigned extra_p;

  always_comb begin
    base_p      = cont_periods(rate);
    extra_p     = single_extra(rate, turbo);
    conv_half   = CNT_W'(2 * base_p);
    single_half = CNT_W'(2 * (base_p + extra_p));
    lead_half   = turbo ? CNT_W'(LEAD_TURBO_HALF) : CNT_W'(LEAD_NORM_HALF);
  end

endmodule

// File: rtl/cts_half_counter.sv
module cts_half_counter #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_ce = 1'b1;
      cnt_d  = load_val;
    end else if (en && (cnt_q != '0)) begin
      cnt_ce = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign expire = en && (cnt_q == '0);

  // R9: a frozen counter keeps its value
  assert_frozen_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/cts_seq_ctrl.sv
module cts_seq_ctrl
  import cts_pkg::*;
#(
  parameter int unsigned CNT_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              turbo_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              cont_i,
  input  logic              start_i,
  input  logic              pd_i,
  input  logic              rd_ack_i,
  input  logic              expire,
  input  logic [CNT_W-1:0]  conv_half,
  input  logic [CNT_W-1:0]  single_half,
  input  logic [CNT_W-1:0]  lead_half,
  output logic [RATE_W-1:0] lut_rate,
  output logic              lut_turbo,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic              cnt_en,
  output logic              drdy_n,
  output logic              done,
  output logic              busy
);

  cts_state_e        state_q, state_d;
  logic              drdy_n_q, drdy_n_d;
  logic              done_q, done_d;
  logic [RATE_W-1:0] rate_q;
  logic              turbo_q, cont_q;
  logic              start_acc;

  assign start_acc = start_i && !pd_i;

  // The table sees the live inputs when a start is accepted, else the held set.
  assign lut_rate  = start_acc ? rate_i  : rate_q;
  assign lut_turbo = start_acc ? turbo_i : turbo_q;

  assign cnt_en = (state_q == ST_RUN) && !pd_i;

  always_comb begin
    state_d      = state_q;
    drdy_n_d     = drdy_n_q;
    done_d       = 1'b0;
    cnt_load     = 1'b0;
    cnt_load_val = conv_half - 1'b1;
    if (pd_i) begin
      state_d  = ST_IDLE;
      drdy_n_d = 1'b1;
    end else if (start_i) begin
      state_d      = ST_RUN;
      drdy_n_d     = 1'b1;
      cnt_load     = 1'b1;
      cnt_load_val = cont_i ? (lead_half + conv_half - 1'b1)
                            : (single_half - 1'b1);
    end else begin
      if (rd_ack_i) drdy_n_d = 1'b1;
      if (expire) begin
        done_d   = 1'b1;
        drdy_n_d = 1'b0;
        if (cont_q) cnt_load = 1'b1;
        else        state_d  = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      drdy_n_q <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      drdy_n_q <= drdy_n_d;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= '0;
      turbo_q <= 1'b0;
      cont_q  <= 1'b0;
    end else if (start_acc) begin
      rate_q  <= rate_i;
      turbo_q <= turbo_i;
      cont_q  <= cont_i;
    end
  end

  assign drdy_n = drdy_n_q;
  assign done   = done_q;
  assign busy   = (state_q == ST_RUN);

  // R10: held settings do not move during a run unless a new start comes
  assert_settings_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_i) |=> ($stable(rate_q) && $stable(turbo_q) && $stable(cont_q)));

  // R5: the counter never expires outside a run
  assert_no_idle_expire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !expire);

endmodule

// File: rtl/conv_timing_seq.sv
module conv_timing_seq
  import cts_pkg::*;
#(
  parameter int unsigned CNT_W           = 18,
  parameter int unsigned LEAD_NORM_HALF  = 57,
  parameter int unsigned LEAD_TURBO_HALF = 210,
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              turbo_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              cont_i,
  input  logic              start_i,
  input  logic              pd_i,
  input  logic              rd_ack_i,
  output logic              drdy_n_o,
  output logic              done_o,
  output logic              busy_o
);

  logic [RST_SYNC_STAGES-1:0] rst_sync_q;
  logic                       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[RST_SYNC_STAGES-1];

  logic [RATE_W-1:0] lut_rate;
  logic              lut_turbo;
  logic [CNT_W-1:0]  conv_half, single_half, lead_half;
  logic              cnt_load, cnt_en, expire;
  logic [CNT_W-1:0]  cnt_load_val;

  cts_rate_lut #(
    .CNT_W          (CNT_W),
    .LEAD_NORM_HALF (LEAD_NORM_HALF),
    .LEAD_TURBO_HALF(LEAD_TURBO_HALF)
  ) u_lut (
    .rate       (lut_rate),
    .turbo      (lut_turbo),
    .conv_half  (conv_half),
    .single_half(single_half),
    .lead_half  (lead_half)
  );

  cts_half_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (cnt_load),
    .load_val(cnt_load_val),
    .en      (cnt_en),
    .expire  (expire)
  );

  cts_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .turbo_i     (turbo_i),
    .rate_i      (rate_i),
    .cont_i      (cont_i),
    .start_i     (start_i),
    .pd_i        (pd_i),
    .rd_ack_i    (rd_ack_i),
    .expire      (expire),
    .conv_half   (conv_half),
    .single_half (single_half),
    .lead_half   (lead_half),
    .lut_rate    (lut_rate),
    .lut_turbo   (lut_turbo),
    .cnt_load    (cnt_load),
    .cnt_load_val(cnt_load_val),
    .cnt_en      (cnt_en),
    .drdy_n      (drdy_n_o),
    .done        (done_o),
    .busy        (busy_o)
  );

  // R6: strobe lasts one tick
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o);

  // R6: strobe coincides with data-ready low
  assert_done_drdy_low_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> !drdy_n_o);

  // R9: power-down silences the outputs
  assert_pd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    pd_i |=> (drdy_n_o && !busy_o && !done_o));

  // R8: an accepted start restarts with data-ready high
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start_i && !pd_i) |=> (busy_o && drdy_n_o && !done_o));

endmodule

// File: tb/tb_conv_timing_seq.sv
module tb_conv_timing_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       turbo_i = 1'b0;
  logic [2:0] rate_i = 3'd6;
  logic       cont_i = 1'b0;
  logic       start_i = 1'b0;
  logic       pd_i = 1'b0;
  logic       rd_ack_i = 1'b0;
  logic       drdy_n_o, done_o, busy_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  conv_timing_seq dut (
    .clk(clk), .rst_n(rst_n), .turbo_i(turbo_i), .rate_i(rate_i),
    .cont_i(cont_i), .start_i(start_i), .pd_i(pd_i), .rd_ack_i(rd_ack_i),
    .drdy_n_o(drdy_n_o), .done_o(done_o), .busy_o(busy_o)
  );

  function automatic int cper(input int idx);
    int t[7] = '{51192, 22780, 11532, 5916, 3116, 1724, 1036};
    return t[(idx > 6) ? 6 : idx];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic pulse_start(input bit turbo, input int rate, input bit cont);
    @(negedge clk);
    turbo_i = turbo; rate_i = 3'(rate); cont_i = cont; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic ticks_to_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done_o && n < 120000);
  endtask

  task automatic quiet_for(input int cyc, output int seen);
    seen = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (done_o) seen++;
    end
  endtask

  task automatic t_reset;
    check(drdy_n_o === 1'b1, "R1 drdy_n", int'(drdy_n_o), 1);
    check(done_o === 1'b0, "R1 done", int'(done_o), 0);
    check(busy_o === 1'b0, "R1 busy", int'(busy_o), 0);
  endtask

  task automatic t_cont_normal;
    int n;
    pulse_start(1'b0, 6, 1'b1);
    ticks_to_done(n);
    check(n == 57 + 2*cper(6), "R2 first edge", n, 57 + 2*cper(6));
    check(drdy_n_o === 1'b0, "R6 drdy low with done", int'(drdy_n_o), 0);
    @(negedge clk);
    check(done_o === 1'b0, "R6 one-tick strobe", int'(done_o), 0);
    repeat (5) @(negedge clk);
    check(drdy_n_o === 1'b0, "R7 held low before read", int'(drdy_n_o), 0);
    rd_ack_i = 1'b1;
    @(negedge clk);
    rd_ack_i = 1'b0;
    check(drdy_n_o === 1'b1, "R7 raised by read", int'(drdy_n_o), 1);
    ticks_to_done(n);
    check(n == 2*cper(6) - 7, "R4 spacing normal", n + 7, 2*cper(6));
    ticks_to_done(n);
    check(n == 2*cper(6), "R4 spacing normal second", n, 2*cper(6));
  endtask

  task automatic t_cont_turbo;
    int n;
    pulse_start(1'b1, 5, 1'b1);
    ticks_to_done(n);
    check(n == 210 + 2*cper(5), "R3 first edge turbo", n, 210 + 2*cper(5));
    ticks_to_done(n);
    check(n == 2*cper(5), "R4 spacing turbo", n, 2*cper(5));
  endtask

  task automatic t_single;
    int n, seen;
    pulse_start(1'b0, 6, 1'b0);
    ticks_to_done(n);
    check(n == 2*(cper(6) + 25), "R5 single normal", n, 2*(cper(6) + 25));
    @(negedge clk);
    check(busy_o === 1'b0, "R5 idle after single", int'(busy_o), 0);
    quiet_for(2500, seen);
    check(seen == 0, "R5 no further done", seen, 0);
    pulse_start(1'b1, 4, 1'b0);
    ticks_to_done(n);
    check(n == 2*(cper(4) + 29), "R5 single turbo", n, 2*(cper(4) + 29));
  endtask

  task automatic t_index7;
    int n;
    pulse_start(1'b0, 7, 1'b0);
    ticks_to_done(n);
    check(n == 2*(cper(6) + 25), "R11 index 7", n, 2*(cper(6) + 25));
  endtask

  task automatic t_restart;
    int n;
    pulse_start(1'b0, 6, 1'b1);
    ticks_to_done(n);
    check(drdy_n_o === 1'b0, "R7 low before restart", int'(drdy_n_o), 0);
    repeat (1000) @(negedge clk);
    pulse_start(1'b0, 6, 1'b1);
    check(drdy_n_o === 1'b1, "R7 raised by start", int'(drdy_n_o), 1);
    ticks_to_done(n);
    check(n == 57 + 2*cper(6), "R8 restart timing", n, 57 + 2*cper(6));
  endtask

  task automatic t_powerdown;
    int n, seen;
    pulse_start(1'b0, 6, 1'b1);
    repeat (500) @(negedge clk);
    pd_i = 1'b1;
    @(negedge clk);
    check(busy_o === 1'b0, "R9 busy off", int'(busy_o), 0);
    check(drdy_n_o === 1'b1, "R9 drdy high", int'(drdy_n_o), 1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    quiet_for(3000, seen);
    check(seen == 0, "R9 no done in power-down", seen, 0);
    check(busy_o === 1'b0, "R9 start ignored", int'(busy_o), 0);
    @(negedge clk);
    pd_i = 1'b0;
    pulse_start(1'b0, 6, 1'b0);
    ticks_to_done(n);
    check(n == 2*(cper(6) + 25), "R9 resume after power-down", n, 2*(cper(6) + 25));
  endtask

  task automatic t_settings;
    int n;
    pulse_start(1'b0, 6, 1'b0);
    repeat (100) @(negedge clk);
    rate_i = 3'd0; turbo_i = 1'b1; cont_i = 1'b1;
    ticks_to_done(n);
    check(n == 2*(cper(6) + 25) - 100, "R10 timing unchanged", n + 100, 2*(cper(6) + 25));
    @(negedge clk);
    check(busy_o === 1'b0, "R10 mode unchanged", int'(busy_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cont_normal();
    t_cont_turbo();
    t_single();
    t_index7();
    t_restart();
    t_powerdown();
    t_settings();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule